// File: doc/BRIEF.md
# Timed Rule Window Monitor

This block watches a running design against a set of timing rules. Each rule ties a trigger event to a target event. It also carries a lower and an upper bound in clock ticks and a level condition, which is a masked compare over a vector of signal levels. After its trigger event has been seen, a rule counts the ticks during which its level condition holds. From that count the block tells whether the rule has waited long enough (satisfied) and whether it has waited too long (expired).

For every event, the block combines the rules that target that event into two flags:

- a permission flag, raised when the event may fire now;
- an obligation flag, raised when the event should already have fired.

Observed events are checked against these flags, and a premature event or an overdue event raises an error flag. The configuration inputs are meant to be held static while the block runs. The rules are packed side by side on these inputs, and a pairwise matrix declares which events exclude each other. Two uses follow from this matrix:

- Rules whose trigger events exclude each other act as alternatives for a shared target.
- Firing one event drops every rule that was waiting on an excluded event.

Top module: `rule_window_monitor`

## Requirements
- R1: While reset is low and after reset is released, no rule is armed, and all rule, permission, obligation and error outputs are zero until an enabling event arrives.
- R2: A rule is enabled when its active bit is set, its trigger event has pulsed at a previous clock edge and not been cleared since, and `(sig_i & mask) == (val & mask)` holds. Signal bits with a zero mask bit have no effect. An inactive rule is never enabled.
- R3: A rule's tick count is 0 in the first enabled cycle after the trigger edge and grows by one per enabled cycle. The rule is satisfied while it is enabled and count >= lower bound.
- R4: If the level condition goes false while a rule is armed, the count returns to 0 and the rule reads not enabled until the condition holds again.
- R5: A rule is expired while it is enabled and count >= upper bound. A rule whose infinite bit is set never expires. The count saturates at the upper bound, or at its maximum value when the bound is infinite.
- R6: may_fire_o[e] is high when at least one active rule targets e and every such rule is satisfied or has a satisfied sibling. A sibling is another rule that targets e and whose trigger event conflicts with its own. The conflict bit for events a,b is conflict_i[a*N_EVENTS+b].
- R7: must_fire_o[e] follows the same rule using expiry instead of satisfaction. late_err_o[e] is high when must_fire_o[e] is high and evt_i[e] is low.
- R8: early_err_o[e] is high when evt_i[e] pulses while e is targeted by an active rule and may_fire_o[e] is low.
- R9: At the edge where event e pulses, every rule targeting e is disarmed, and so is every rule whose target conflicts with e. An event that arms a rule at the same edge takes priority and restarts that rule at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_i | input | N_SIGS | Current signal levels |
| evt_i | input | N_EVENTS | One-cycle event pulses observed this cycle |
| rule_act_i | input | N_RULES | Rule active bits |
| rule_src_i | input | N_RULES*EW | Trigger event index per rule |
| rule_dst_i | input | N_RULES*EW | Target event index per rule |
| rule_lo_i | input | N_RULES*CNT_W | Lower bound per rule |
| rule_hi_i | input | N_RULES*CNT_W | Upper bound per rule |
| rule_inf_i | input | N_RULES | Upper bound is infinite |
| rule_mask_i | input | N_RULES*N_SIGS | Level condition mask per rule |
| rule_val_i | input | N_RULES*N_SIGS | Level condition value per rule |
| conflict_i | input | N_EVENTS*N_EVENTS | Event conflict matrix |
| rule_en_o | output | N_RULES | Rule enabled |
| rule_sat_o | output | N_RULES | Rule satisfied |
| rule_exp_o | output | N_RULES | Rule expired |
| may_fire_o | output | N_EVENTS | Event permitted now |
| must_fire_o | output | N_EVENTS | Event overdue |
| early_err_o | output | N_EVENTS | Event fired before permitted |
| late_err_o | output | N_EVENTS | Event absent while overdue |

## Verification
The hardest states to reach are the ones where two kinds of interplay decide the result. The first kind is conflict among trigger events, where one satisfied rule must excuse a sibling that was never triggered. The second is conflict among target events, where firing one event silently drops a rule aimed at another. The stimulus arms only one of two alternative triggers and then walks the count through the lower and upper bounds. It also arms two rules from one trigger and fires the excluded target. An unbounded rule is then held for more cycles than the counter can represent. This shows that saturation never turns into expiry.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

   // Per-rule status reported from a rule slot.
   typedef struct packed {
      logic en;
      logic sat;
      logic exp;
   } rwm_flags_t;

endpackage

// File: rtl/rwm_rule_slot.sv
module rwm_rule_slot
   import rwm_pkg::*;
#(
   parameter int N_SIGS = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              kill_i,
   input  logic [N_SIGS-1:0] sig_i,
   input  logic [N_SIGS-1:0] mask_i,
   input  logic [N_SIGS-1:0] val_i,
   input  logic [CNT_W-1:0]  lo_i,
   input  logic [CNT_W-1:0]  hi_i,
   input  logic              inf_i,
   output rwm_flags_t        flags_o
);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap;
   logic             match;

   assign match = ((sig_i ^ val_i) & mask_i) == '0;
   assign cap   = inf_i ? {CNT_W{1'b1}} : hi_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm_i && (!armed_q || kill_i)) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (kill_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (armed_q) begin
         if (!match)
            cnt_q <= '0;
         else if (cnt_q != cap)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      flags_o.en  = armed_q && match;
      flags_o.sat = flags_o.en && (cnt_q >= lo_i);
      flags_o.exp = flags_o.en && !inf_i && (cnt_q >= hi_i);
   end

endmodule

// File: rtl/rwm_event_eval.sv
module rwm_event_eval #(
   parameter int N_RULES = 8
) (
   input  logic                       evt_i,
   input  logic [N_RULES-1:0]         tgt_i,
   input  logic [N_RULES-1:0]         sat_i,
   input  logic [N_RULES-1:0]         exp_i,
   input  logic [N_RULES*N_RULES-1:0] peer_i,
   output logic                       may_o,
   output logic                       must_o,
   output logic                       early_o,
   output logic                       late_o
);

   logic [N_RULES-1:0] cov_sat;
   logic [N_RULES-1:0] cov_exp;
   logic               targeted;

   for (genvar r = 0; r < N_RULES; r++) begin : g_cover
      assign cov_sat[r] = sat_i[r] | (|(sat_i & tgt_i & peer_i[r*N_RULES +: N_RULES]));
      assign cov_exp[r] = exp_i[r] | (|(exp_i & tgt_i & peer_i[r*N_RULES +: N_RULES]));
   end

   assign targeted = |tgt_i;
   assign may_o    = targeted && (&(~tgt_i | cov_sat));
   assign must_o   = targeted && (&(~tgt_i | cov_exp));
   assign early_o  = evt_i && targeted && !may_o;
   assign late_o   = must_o && !evt_i;

endmodule

// File: rtl/rule_window_monitor.sv
module rule_window_monitor
   import rwm_pkg::*;
#(
   parameter int N_RULES  = 8,
   parameter int N_SIGS   = 8,
   parameter int N_EVENTS = 8,
   parameter int CNT_W    = 8,
   localparam int EW      = (N_EVENTS > 1) ? $clog2(N_EVENTS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SIGS-1:0]            sig_i,
   input  logic [N_EVENTS-1:0]          evt_i,
   input  logic [N_RULES-1:0]           rule_act_i,
   input  logic [N_RULES*EW-1:0]        rule_src_i,
   input  logic [N_RULES*EW-1:0]        rule_dst_i,
   input  logic [N_RULES*CNT_W-1:0]     rule_lo_i,
   input  logic [N_RULES*CNT_W-1:0]     rule_hi_i,
   input  logic [N_RULES-1:0]           rule_inf_i,
   input  logic [N_RULES*N_SIGS-1:0]    rule_mask_i,
   input  logic [N_RULES*N_SIGS-1:0]    rule_val_i,
   input  logic [N_EVENTS*N_EVENTS-1:0] conflict_i,
   output logic [N_RULES-1:0]           rule_en_o,
   output logic [N_RULES-1:0]           rule_sat_o,
   output logic [N_RULES-1:0]           rule_exp_o,
   output logic [N_EVENTS-1:0]          may_fire_o,
   output logic [N_EVENTS-1:0]          must_fire_o,
   output logic [N_EVENTS-1:0]          early_err_o,
   output logic [N_EVENTS-1:0]          late_err_o
);

   // Elaboration-time parameter checks
   if (N_RULES < 1 || N_RULES > 32) begin : g_bad_rules
      $error("rule_window_monitor: N_RULES out of range");
   end
   if (N_EVENTS < 2 || (1 << EW) != N_EVENTS) begin : g_bad_events
      $error("rule_window_monitor: N_EVENTS must be a power of two >= 2");
   end
   if (N_SIGS < 1 || CNT_W < 2) begin : g_bad_widths
      $error("rule_window_monitor: N_SIGS or CNT_W too small");
   end

   logic [EW-1:0]              src_a [N_RULES];
   logic [EW-1:0]              dst_a [N_RULES];
   logic [N_RULES-1:0]         arm;
   logic [N_RULES-1:0]         kill;
   logic [N_RULES*N_RULES-1:0] peer;
   rwm_flags_t                 flags [N_RULES];

   for (genvar r = 0; r < N_RULES; r++) begin : g_rule
      logic [N_EVENTS-1:0] dst_row;

      assign src_a[r]   = rule_src_i[r*EW +: EW];
      assign dst_a[r]   = rule_dst_i[r*EW +: EW];
      assign dst_row    = conflict_i[dst_a[r]*N_EVENTS +: N_EVENTS];
      assign arm[r]     = rule_act_i[r] && evt_i[src_a[r]];
      assign kill[r]    = evt_i[dst_a[r]] || (|(evt_i & dst_row));

      for (genvar q = 0; q < N_RULES; q++) begin : g_peer
         if (q == r) begin : g_self
            assign peer[r*N_RULES+q] = 1'b0;
         end else begin : g_other
            assign peer[r*N_RULES+q] = conflict_i[src_a[r]*N_EVENTS + src_a[q]];
         end
      end

      rwm_rule_slot #(
         .N_SIGS (N_SIGS),
         .CNT_W  (CNT_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm_i   (arm[r]),
         .kill_i  (kill[r]),
         .sig_i   (sig_i),
         .mask_i  (rule_mask_i[r*N_SIGS +: N_SIGS]),
         .val_i   (rule_val_i[r*N_SIGS +: N_SIGS]),
         .lo_i    (rule_lo_i[r*CNT_W +: CNT_W]),
         .hi_i    (rule_hi_i[r*CNT_W +: CNT_W]),
         .inf_i   (rule_inf_i[r]),
         .flags_o (flags[r])
      );

      assign rule_en_o[r]  = flags[r].en;
      assign rule_sat_o[r] = flags[r].sat;
      assign rule_exp_o[r] = flags[r].exp;
   end

   for (genvar e = 0; e < N_EVENTS; e++) begin : g_event
      logic [N_RULES-1:0] tgt;

      for (genvar r = 0; r < N_RULES; r++) begin : g_tgt
         assign tgt[r] = rule_act_i[r] && (dst_a[r] == EW'(e));
      end

      rwm_event_eval #(
         .N_RULES (N_RULES)
      ) u_eval (
         .evt_i   (evt_i[e]),
         .tgt_i   (tgt),
         .sat_i   (rule_sat_o),
         .exp_i   (rule_exp_o),
         .peer_i  (peer),
         .may_o   (may_fire_o[e]),
         .must_o  (must_fire_o[e]),
         .early_o (early_err_o[e]),
         .late_o  (late_err_o[e])
      );
   end

endmodule

// File: rtl/rwm_checker.sv
module rwm_checker #(
   parameter int N_RULES  = 8,
   parameter int N_EVENTS = 8,
   parameter int EW       = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N_EVENTS-1:0]   evt_i,
   input logic [N_RULES-1:0]    rule_act_i,
   input logic [N_RULES*EW-1:0] rule_src_i,
   input logic [N_RULES*EW-1:0] rule_dst_i,
   input logic [N_RULES-1:0]    rule_en_o,
   input logic [N_RULES-1:0]    rule_sat_o,
   input logic [N_RULES-1:0]    rule_exp_o,
   input logic [N_EVENTS-1:0]   may_fire_o,
   input logic [N_EVENTS-1:0]   must_fire_o,
   input logic [N_EVENTS-1:0]   early_err_o,
   input logic [N_EVENTS-1:0]   late_err_o
);

   assert_sat_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rule_sat_o & ~rule_en_o) == '0);

   assert_exp_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rule_exp_o & ~rule_en_o) == '0);

   assert_early_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (early_err_o & ~evt_i) == '0);

   assert_early_excludes_may_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (early_err_o & may_fire_o) == '0);

   assert_late_needs_must_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (late_err_o & ~must_fire_o) == '0);

   for (genvar r = 0; r < N_RULES; r++) begin : g_rule_chk
      assert_inactive_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !rule_act_i[r] |-> !rule_en_o[r]);

      assert_fire_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[rule_dst_i[r*EW +: EW]] && !evt_i[rule_src_i[r*EW +: EW]])
         |=> !rule_en_o[r]);
   end

endmodule

bind rule_window_monitor rwm_checker #(
   .N_RULES  (N_RULES),
   .N_EVENTS (N_EVENTS),
   .EW       (EW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .rule_act_i  (rule_act_i),
   .rule_src_i  (rule_src_i),
   .rule_dst_i  (rule_dst_i),
   .rule_en_o   (rule_en_o),
   .rule_sat_o  (rule_sat_o),
   .rule_exp_o  (rule_exp_o),
   .may_fire_o  (may_fire_o),
   .must_fire_o (must_fire_o),
   .early_err_o (early_err_o),
   .late_err_o  (late_err_o)
);

// File: tb/rule_window_monitor_test.sv
module rule_window_monitor_test;

   localparam int NR = 8;
   localparam int NS = 8;
   localparam int NE = 8;
   localparam int CW = 8;
   localparam int EW = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NS-1:0]    sig_i = '0;
   logic [NE-1:0]    evt_i = '0;
   logic [NR-1:0]    rule_act_i = '0;
   logic [NR*EW-1:0] rule_src_i = '0;
   logic [NR*EW-1:0] rule_dst_i = '0;
   logic [NR*CW-1:0] rule_lo_i = '0;
   logic [NR*CW-1:0] rule_hi_i = '0;
   logic [NR-1:0]    rule_inf_i = '0;
   logic [NR*NS-1:0] rule_mask_i = '0;
   logic [NR*NS-1:0] rule_val_i = '0;
   logic [NE*NE-1:0] conflict_i = '0;
   logic [NR-1:0]    rule_en_o, rule_sat_o, rule_exp_o;
   logic [NE-1:0]    may_fire_o, must_fire_o, early_err_o, late_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rule_window_monitor #(.N_RULES(NR), .N_SIGS(NS), .N_EVENTS(NE), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .evt_i(evt_i),
      .rule_act_i(rule_act_i), .rule_src_i(rule_src_i), .rule_dst_i(rule_dst_i),
      .rule_lo_i(rule_lo_i), .rule_hi_i(rule_hi_i), .rule_inf_i(rule_inf_i),
      .rule_mask_i(rule_mask_i), .rule_val_i(rule_val_i), .conflict_i(conflict_i),
      .rule_en_o(rule_en_o), .rule_sat_o(rule_sat_o), .rule_exp_o(rule_exp_o),
      .may_fire_o(may_fire_o), .must_fire_o(must_fire_o),
      .early_err_o(early_err_o), .late_err_o(late_err_o));

   // Rows: {evt[7:0], sig[7:0], en0, sat0, exp0, may1, must1, early1, late1}
   // Rule 0: trigger e0, target e1, lo 2, hi 4, needs sig bit 0 high.
   localparam logic [22:0] TAB [13] = '{
      {8'h01, 8'h01, 7'b0000000},  // trigger pulse, not yet armed (R2)
      {8'h00, 8'h01, 7'b1000000},  // count 0 (R3)
      {8'h00, 8'hF1, 7'b1000000},  // count 1, unmasked bits ignored (R2)
      {8'h00, 8'h01, 7'b1101000},  // count 2: satisfied, e1 permitted (R3 R6)
      {8'h00, 8'hFE, 7'b0000000},  // level drop (R4)
      {8'h00, 8'h01, 7'b1000000},  // restarted at 0 (R4)
      {8'h00, 8'h01, 7'b1000000},
      {8'h00, 8'h81, 7'b1101000},
      {8'h00, 8'h01, 7'b1101000},
      {8'h00, 8'h01, 7'b1111101},  // count 4: expired, overdue (R5 R7)
      {8'h02, 8'h01, 7'b1111100},  // saturated, target fires, no late (R5 R7)
      {8'h02, 8'h01, 7'b0000010},  // disarmed; second pulse is early (R9 R8)
      {8'h00, 8'h01, 7'b0000000}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [NE-1:0] e, input logic [NS-1:0] s);
      @(negedge clk);
      evt_i = e;
      sig_i = s;
      #2;
   endtask

   task automatic set_rule(input int r, input int s, input int d, input int lo,
                           input int hi, input bit inf, input int m, input int v);
      rule_act_i[r]          = 1'b1;
      rule_src_i[r*EW +: EW] = EW'(s);
      rule_dst_i[r*EW +: EW] = EW'(d);
      rule_lo_i[r*CW +: CW]  = CW'(lo);
      rule_hi_i[r*CW +: CW]  = CW'(hi);
      rule_inf_i[r]          = inf;
      rule_mask_i[r*NS +: NS] = NS'(m);
      rule_val_i[r*NS +: NS]  = NS'(v);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      set_rule(0, 0, 1, 2, 4, 1'b0, 8'h01, 8'h01);
      set_rule(1, 2, 3, 1, 2, 1'b0, 8'h00, 8'h00);
      set_rule(2, 4, 3, 1, 3, 1'b0, 8'h00, 8'h00);
      set_rule(3, 5, 6, 0, 0, 1'b1, 8'h00, 8'h00);
      set_rule(4, 5, 7, 0, 1, 1'b0, 8'h00, 8'h00);
      conflict_i[2*NE+4] = 1'b1;
      conflict_i[4*NE+2] = 1'b1;
      conflict_i[6*NE+7] = 1'b1;
      conflict_i[7*NE+6] = 1'b1;

      // R1: reset state, with an event pulsing during reset
      evt_i = 8'h01;
      sig_i = 8'h01;
      repeat (3) @(negedge clk);
      check("R1 en during reset", int'(rule_en_o), 0);
      evt_i = '0;
      rst_n = 1'b1;
      step(8'h00, 8'h01);
      check("R1 en after reset", int'(rule_en_o), 0);
      check("R1 may after reset", int'(may_fire_o), 0);
      check("R1 errors after reset", int'({early_err_o, late_err_o, must_fire_o}), 0);

      // Vector table: rule 0 through its whole window (R2 R3 R4 R5 R6 R7 R8 R9)
      for (int i = 0; i < 13; i++) begin
         step(TAB[i][22:15], TAB[i][14:7]);
         check($sformatf("R3 R5 row %0d rule0 flags", i),
               int'({rule_en_o[0], rule_sat_o[0], rule_exp_o[0]}), int'(TAB[i][6:4]));
         check($sformatf("R6 R7 R8 row %0d event1 flags", i),
               int'({may_fire_o[1], must_fire_o[1], early_err_o[1], late_err_o[1]}),
               int'(TAB[i][3:0]));
         check($sformatf("R2 row %0d inactive rules", i), int'(rule_en_o[7:5]), 0);
      end

      // R6/R7: e2 and e4 conflict; only e2 arms, rule 1 covers rule 2
      step(8'h04, 8'h00);
      step(8'h00, 8'h00);
      check("R3 rule1 count0 not sat", int'({rule_en_o[2:1], rule_sat_o[1]}), 'b010);
      check("R6 e3 not yet permitted", int'(may_fire_o[3]), 0);
      step(8'h00, 8'h00);
      check("R6 e3 permitted by conflict sibling", int'(may_fire_o[3]), 1);
      check("R7 e3 not overdue", int'(must_fire_o[3]), 0);
      step(8'h00, 8'h00);
      check("R7 e3 overdue", int'({must_fire_o[3], late_err_o[3]}), 'b11);
      step(8'h08, 8'h00);
      check("R7 R8 e3 fires in window end", int'({late_err_o[3], early_err_o[3]}), 0);
      step(8'h00, 8'h00);
      check("R9 rule1 disarmed", int'(rule_en_o[1]), 0);

      // R5/R9: one trigger, conflicting targets e6/e7, rule 3 unbounded
      step(8'h20, 8'h00);
      check("R2 not armed at trigger cycle", int'(rule_en_o[4:3]), 0);
      step(8'h00, 8'h00);
      check("R3 lo 0 satisfied", int'({rule_sat_o[4:3], may_fire_o[7:6]}), 'b1111);
      check("R5 rule4 count0 not expired", int'(rule_exp_o[4]), 0);
      step(8'h00, 8'h00);
      check("R5 rule4 expired", int'({rule_exp_o[4], late_err_o[7]}), 'b11);
      for (int k = 0; k < 300; k++) step(8'h00, 8'h00);
      check("R5 unbounded rule never expires", int'({rule_sat_o[3], rule_exp_o[3]}), 'b10);
      check("R5 e6 never overdue", int'(must_fire_o[6]), 0);
      step(8'h80, 8'h00);
      check("R7 e7 fired, no late", int'(late_err_o[7]), 0);
      step(8'h00, 8'h00);
      check("R9 conflicting target discarded", int'(rule_en_o[4:3]), 0);
      check("R9 e6 no longer permitted", int'(may_fire_o[6]), 0);

      // R1: reset while armed
      step(8'h01, 8'h01);
      step(8'h00, 8'h01);
      check("R2 rule0 re-armed", int'(rule_en_o[0]), 1);
      rst_n = 1'b0;
      #1;
      check("R1 reset clears armed rule", int'(rule_en_o[0]), 0);
      rst_n = 1'b1;
      step(8'h00, 8'h01);
      check("R1 stays idle after reset", int'(rule_en_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule